// File: doc/BRIEF.md
# Set-Dueling Insertion Policy Selector

This unit decides, for a whole cache, whether incoming lines should be inserted with the classic most-recently-used placement (LRU insertion) or with bimodal insertion (BIP), where most fills land at the least-recently-used position. Two small groups of sets act as fixed samples. One group always inserts LRU-style and the other always inserts bimodally. Every miss reported in a sample set moves a shared saturating selection counter. A miss in the LRU sample pushes the counter up and a miss in the bimodal sample pulls it down. The counter therefore leans toward the policy that is currently missing less.

All other sets are followers. They take the policy the counter favours. The replacement logic asks the unit about any set index and gets back the insertion mode for that set and a flag that says whether the set is a sample (leader) set. Miss events arrive as a valid strobe with the set index. The selection counter is the only storage.

Set classification splits the index into a low half and a high half. A set is a bimodal leader when the two halves are equal. It is an LRU leader when the low half equals the bitwise inverse of the high half. With 1024 sets this gives 32 leaders for each policy. Internally each clock applies one of three counter steps, named HOLD, UP and DOWN. HOLD covers no miss or a follower miss. UP covers an LRU-leader miss. DOWN covers a bimodal-leader miss. An UP at the maximum or a DOWN at zero falls back to HOLD, which is the saturation transition.

Top module: `duel_ins_sel`

## Requirements
- R1: After reset the selection counter holds its midpoint (512 for 10 bits). Because that value has its MSB set, follower sets report bimodal mode (`query_mode` = 1) right after reset.
- R2: A queried set whose index bits [4:0] equal bits [9:5] is a bimodal leader. It reports `query_leader` = 1 and `query_mode` = 1.
- R3: A queried set whose index bits [4:0] equal the bitwise inverse of bits [9:5] is an LRU leader. It reports `query_leader` = 1 and `query_mode` = 0.
- R4: Every other set reports `query_leader` = 0.
- R5: A clock edge with `miss_valid` = 1 and an LRU-leader `miss_set` increments the counter by one.
- R6: A clock edge with `miss_valid` = 1 and a bimodal-leader `miss_set` decrements the counter by one.
- R7: A miss in a follower set, or any cycle with `miss_valid` = 0, leaves the counter unchanged.
- R8: A follower set reports `query_mode` equal to the counter MSB (1 = bimodal, 0 = LRU). A counter change shows up on the query outputs in the cycle after the clock edge that makes it. The query path itself is combinational.
- R9: The counter saturates at 1023 and at 0 and never wraps.
- R10: Leader sets report their fixed mode whatever the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss occurred this cycle |
| miss_set | input | 10 | Set index of the miss |
| query_set | input | 10 | Set index being asked about |
| query_mode | output | 1 | Insertion mode for `query_set`: 0 = LRU, 1 = bimodal |
| query_leader | output | 1 | `query_set` is a sample (leader) set |

## Verification
The bench goes after the counter boundaries. It drives long runs of LRU-leader misses past 1023 and then enough bimodal-leader misses to cross zero. A counter that wraps would flip the follower mode at the wrong moment, and the follower output would expose it. It also brings the counter back to 511 and then 512, because that crossing is the only point where the follower mode turns over. A design with an off-by-one midpoint or a mis-chosen MSB would report the wrong follower mode there. Follower misses and idle cycles with a leader index on `miss_set` are mixed in; a design that counted them would drift the crossing point. The corner indices 0, 31, 992 and 1023 are queried while the counter sits at both extremes, which catches leader tests with swapped halves or leaders that follow the counter.

// File: rtl/duel_ins_pkg.sv
package duel_ins_pkg;

    typedef enum logic {
        INS_LRU = 1'b0,
        INS_BIP = 1'b1
    } ins_mode_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

    typedef struct packed {
        logic bip_lead;
        logic lru_lead;
    } set_class_t;

endpackage

// File: rtl/duel_set_class.sv
module duel_set_class
    import duel_ins_pkg::*;
#(
    parameter int SET_BITS = 10
) (
    input  logic [SET_BITS-1:0] set_idx,
    output set_class_t          cls
);
    localparam int HALF = SET_BITS / 2;

    logic [HALF-1:0] lo_half;
    logic [HALF-1:0] hi_half;

    always_comb begin
        lo_half      = set_idx[HALF-1:0];
        hi_half      = set_idx[2*HALF-1:HALF];
        cls.bip_lead = (lo_half == hi_half);
        cls.lru_lead = (lo_half == ~hi_half);
    end
endmodule

// File: rtl/duel_psel.sv
module duel_psel
    import duel_ins_pkg::*;
#(
    parameter int CNT_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  step_t               step,
    output logic [CNT_BITS-1:0] cnt,
    output logic                favour_bip
);
    localparam logic [CNT_BITS-1:0] CNT_MID = {1'b1, {(CNT_BITS-1){1'b0}}};
    localparam logic [CNT_BITS-1:0] CNT_MAX = {CNT_BITS{1'b1}};
    localparam logic [CNT_BITS-1:0] CNT_MIN = '0;

    logic [CNT_BITS-1:0] cnt_q;
    logic [CNT_BITS-1:0] cnt_d;
    step_t               step_eff;

    // saturation folds a blocked step back to HOLD
    always_comb begin
        step_eff = step;
        if (step == STEP_UP   && cnt_q == CNT_MAX) step_eff = STEP_HOLD;
        if (step == STEP_DOWN && cnt_q == CNT_MIN) step_eff = STEP_HOLD;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (step_eff)
            STEP_HOLD: cnt_d = cnt_q;
            STEP_UP:   cnt_d = cnt_q + 1'b1;
            STEP_DOWN: cnt_d = cnt_q - 1'b1;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CNT_MID;
        else        cnt_q <= cnt_d;
    end

    assign cnt        = cnt_q;
    assign favour_bip = cnt_q[CNT_BITS-1];
endmodule

// File: rtl/duel_ins_sel.sv
module duel_ins_sel
    import duel_ins_pkg::*;
#(
    parameter int SET_BITS = 10,
    parameter int CNT_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                miss_valid,
    input  logic [SET_BITS-1:0] miss_set,
    input  logic [SET_BITS-1:0] query_set,
    output logic                query_mode,
    output logic                query_leader
);
    set_class_t          miss_cls;
    set_class_t          qry_cls;
    step_t               step;
    logic [CNT_BITS-1:0] psel_q;
    logic                favour_bip;
    ins_mode_t           mode;

    duel_set_class #(.SET_BITS(SET_BITS)) miss_cls_i (
        .set_idx (miss_set),
        .cls     (miss_cls)
    );

    duel_set_class #(.SET_BITS(SET_BITS)) qry_cls_i (
        .set_idx (query_set),
        .cls     (qry_cls)
    );

    always_comb begin
        step = STEP_HOLD;
        if (miss_valid) begin
            unique case ({miss_cls.lru_lead, miss_cls.bip_lead})
                2'b10:   step = STEP_UP;
                2'b01:   step = STEP_DOWN;
                default: step = STEP_HOLD;
            endcase
        end
    end

    duel_psel #(.CNT_BITS(CNT_BITS)) psel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .cnt        (psel_q),
        .favour_bip (favour_bip)
    );

    always_comb begin
        unique case ({qry_cls.lru_lead, qry_cls.bip_lead})
            2'b10:   mode = INS_LRU;
            2'b01:   mode = INS_BIP;
            default: mode = favour_bip ? INS_BIP : INS_LRU;
        endcase
    end

    assign query_mode   = mode;
    assign query_leader = qry_cls.lru_lead | qry_cls.bip_lead;
endmodule

// File: rtl/duel_ins_sel_chk.sv
module duel_ins_sel_chk #(
    parameter int SET_BITS = 10,
    parameter int CNT_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                miss_valid,
    input logic [SET_BITS-1:0] miss_set,
    input logic [SET_BITS-1:0] query_set,
    input logic                query_mode,
    input logic                query_leader,
    input logic [CNT_BITS-1:0] psel_q
);
    localparam int HALF = SET_BITS / 2;
    localparam logic [CNT_BITS-1:0] MAXV = {CNT_BITS{1'b1}};
    localparam logic [CNT_BITS-1:0] MIDV = {1'b1, {(CNT_BITS-1){1'b0}}};

    logic m_bip, m_lru, q_bip, q_lru;
    always_comb begin
        m_bip = (miss_set[HALF-1:0] == miss_set[2*HALF-1:HALF]);
        m_lru = (miss_set[HALF-1:0] == ~miss_set[2*HALF-1:HALF]);
        q_bip = (query_set[HALF-1:0] == query_set[2*HALF-1:HALF]);
        q_lru = (query_set[HALF-1:0] == ~query_set[2*HALF-1:HALF]);
    end

    // R1
    reset_mid_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> psel_q == MIDV);

    // R5
    lru_miss_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && m_lru && psel_q != MAXV) |=> psel_q == $past(psel_q) + 1'b1);

    // R6
    bip_miss_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && m_bip && psel_q != '0) |=> psel_q == $past(psel_q) - 1'b1);

    // R7
    follower_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_valid || (!m_bip && !m_lru)) |=> $stable(psel_q));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_q == MAXV && miss_valid && m_lru) |=> psel_q == MAXV);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_q == '0 && miss_valid && m_bip) |=> psel_q == '0);

    // R10
    leader_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_bip || q_lru) |-> (query_leader && query_mode == q_bip));
endmodule

bind duel_ins_sel duel_ins_sel_chk #(.SET_BITS(SET_BITS), .CNT_BITS(CNT_BITS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_set     (miss_set),
    .query_set    (query_set),
    .query_mode   (query_mode),
    .query_leader (query_leader),
    .psel_q       (psel_q)
);

// File: tb/duel_ins_sel_tb.sv
module duel_ins_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss_valid = 1'b0;
    logic [9:0] miss_set = '0;
    logic [9:0] query_set = '0;
    logic       query_mode;
    logic       query_leader;

    int checks = 0;
    int errors = 0;
    int ref_psel = 512;
    bit done = 0;

    always #2 clk = ~clk;

    duel_ins_sel dut_i (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_set(miss_set),
        .query_set(query_set), .query_mode(query_mode), .query_leader(query_leader)
    );

    // 0 follower, 1 bimodal leader, 2 LRU leader
    function automatic int kind_of(int s);
        int lo = s % 32;
        int hi = s / 32;
        if (lo == hi) return 1;
        if (lo == 31 - hi) return 2;
        return 0;
    endfunction

    function automatic int pick(int k);
        int hi;
        int s;
        hi = int'($urandom_range(0, 31));
        if (k == 1) return hi * 32 + hi;
        if (k == 2) return hi * 32 + (31 - hi);
        do s = int'($urandom_range(0, 1023)); while (kind_of(s) != 0);
        return s;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (set %0d, ref counter %0d)",
                     req, act, exp, query_set, ref_psel);
        end
    endtask

    // compare outputs against the model, then apply one cycle of stimulus
    task automatic cycle(bit mv, int ms, int qs);
        int k;
        int exp_mode;
        @(negedge clk);
        k = kind_of(int'(query_set));
        exp_mode = (k == 1) ? 1 : (k == 2) ? 0 : (ref_psel >= 512 ? 1 : 0);
        // R2 R3 R8 R10 per-cycle mode, R4 leader flag
        check(k == 1 ? "R2/R10" : k == 2 ? "R3/R10" : "R8", int'(query_mode), exp_mode);
        check("R4", int'(query_leader), (k != 0) ? 1 : 0);
        miss_valid = mv;
        miss_set   = 10'(ms);
        query_set  = 10'(qs);
        @(posedge clk);
        if (mv) begin
            if (kind_of(ms) == 2 && ref_psel < 1023) ref_psel++;      // R5 R9
            else if (kind_of(ms) == 1 && ref_psel > 0) ref_psel--;    // R6 R9
        end                                                           // R7
    endtask

    task automatic burst(int n, int mk, int pct_valid);
        for (int i = 0; i < n; i++)
            cycle($urandom_range(0, 99) < pct_valid, pick(mk),
                  pick(int'($urandom_range(0, 2))));
    endtask

    initial begin
        int corners[4] = '{0, 31, 992, 1023};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        ref_psel = 512;
        // R1 followers report bimodal straight after reset
        query_set = 10'd1;
        cycle(0, 0, 1);
        cycle(0, 0, 5);
        // R6 R8 one bimodal-leader miss drops to 511 -> followers turn LRU
        cycle(1, 33, 5);
        cycle(0, 0, 5);
        check("R8", int'(query_mode), 0);
        // R5 R8 one LRU-leader miss back to 512 -> bimodal
        cycle(1, 31, 5);
        cycle(0, 0, 5);
        check("R8", int'(query_mode), 1);
        // R7 idle cycles with a leader index and follower misses
        for (int i = 0; i < 50; i++) cycle(0, pick(2), 5);
        burst(200, 0, 100);
        cycle(0, 0, 5);
        check("R7", int'(query_mode), 1);
        // R9 saturate high, then R10 corner leaders at the top
        burst(700, 2, 90);
        foreach (corners[i]) cycle(1, pick(2), corners[i]);
        cycle(0, 0, 1);
        check("R9", ref_psel, 1023);
        // R9 saturate low, corners at the bottom
        burst(1200, 1, 95);
        foreach (corners[i]) cycle(1, pick(1), corners[i]);
        cycle(0, 0, 1);
        check("R9", ref_psel, 0);
        // climb to 511 exactly, then one more
        for (int i = 0; i < 511; i++) cycle(1, pick(2), 7);
        cycle(0, 0, 7);
        check("R8", int'(query_mode), 0);
        cycle(1, pick(2), 7);
        cycle(0, 0, 7);
        check("R8", int'(query_mode), 1);
        // mixed traffic
        for (int i = 0; i < 3000; i++)
            cycle($urandom_range(0, 1), pick(int'($urandom_range(0, 2))),
                  int'($urandom_range(0, 1023)));
        cycle(0, 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule